// File: doc/BRIEF.md
# Subtract-and-Swap GCD Engine

This block computes the greatest common divisor of two unsigned operands. It repeatedly subtracts the smaller value from the larger one and swaps the two values when needed. A one-cycle start pulse loads both operands. The engine then runs on its own and raises a done flag, with the result on the output, when the second value reaches zero. The result stays on the output until the next start pulse.

The datapath has two registers, X and Y, each with its own load enable. A single subtractor computes X minus Y at one bit wider than the operands. The extra top bit of the subtractor output is the unsigned "X is smaller" flag, so no separate comparator is needed. A zero detector watches Y. Both flags are stored in registers before the controller reads them. For this reason every operation is followed by one settling cycle in which the flags catch up with the new register contents.

On a swap, X loads Y through the next-X multiplexer and Y loads X, in the same clock edge. On a subtract, only X loads, and it takes the difference.

Top module: `gcd_sub_swap`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o` is 0 and `result_o` is 0.
- R2: A start pulse seen in the idle or done state loads `opa_i` into X and `opb_i` into Y at that clock edge. `done_o` is 0 in the following cycle.
- R3: When `done_o` is 1, `result_o` equals gcd(A, B) of the accepted operands. If one operand is zero the result is the other operand, and gcd(0, 0) is 0.
- R4: The X-is-smaller decision is a correct unsigned comparison over the full width, even when X − Y has its most significant operand bit set. For example, A = 0xC0000000 and B = 0x40000000 give 0x40000000. The X-is-smaller flag and the Y-is-zero flag are never 1 together.
- R5: A swap writes the old Y into X and the old X into Y at the same clock edge.
- R6: A subtract writes X − Y into X and leaves Y unchanged.
- R7: The controller acts only on the registered flags. Each swap or subtract is followed by one cycle with no register update. If n operations are needed, `done_o` rises 2n + 2 cycles after the edge that accepted the start pulse.
- R8: While the engine is done and no start pulse arrives, `done_o` stays 1, `result_o` stays unchanged, and Y is zero.
- R9: A start pulse that arrives while a computation is running is ignored. The running computation finishes with its own operands and its own latency.
- R10: A start pulse in the done state begins a new computation with the new operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; loads the operands when the engine is not running |
| opa_i | input | WIDTH | First operand (A) |
| opb_i | input | WIDTH | Second operand (B) |
| done_o | output | 1 | High while the result is valid |
| result_o | output | WIDTH | The GCD (the contents of the X register) |

## Verification
The bench builds the engine with the default WIDTH of 32. At that width the subtractor's extra borrow bit matters: operand pairs whose difference sets bit 31 would make the comparison go wrong if the borrow bit were dropped. Random operand pairs are kept to ten bits so that runs dominated by subtraction stay short. Directed pairs near the top of the 32-bit range then exercise the swap and compare paths at full width. The bench also predicts the exact operation count n for every pair, so each latency check compares against 2n + 2 cycles.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } gcd_state_e;

    typedef enum logic [1:0] {
        XSRC_OPND = 2'd0,
        XSRC_Y    = 2'd1,
        XSRC_DIFF = 2'd2
    } gcd_xsrc_e;

    typedef struct packed {
        logic      load;
        logic      x_en;
        logic      y_en;
        gcd_xsrc_e xsrc;
    } gcd_ctl_t;

    typedef struct packed {
        logic lt;
        logic zero;
    } gcd_flags_t;

    function automatic gcd_ctl_t ctl_make(logic ld, logic xe, logic ye, gcd_xsrc_e src);
        gcd_ctl_t c;
        c.load = ld;
        c.x_en = xe;
        c.y_en = ye;
        c.xsrc = src;
        return c;
    endfunction

endpackage

// File: rtl/gcd_dpath.sv
module gcd_dpath
    import gcd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  gcd_ctl_t         ctl,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] x_q,
    output logic [WIDTH-1:0] y_q,
    output gcd_flags_t       flags_q
);
    localparam int DW = WIDTH + 1;

    logic [DW-1:0]    diff_w;
    logic [WIDTH-1:0] x_next;
    logic [WIDTH-1:0] y_next;
    gcd_flags_t       flags_next;

    // one subtractor, one bit wider: top bit is the unsigned borrow
    assign diff_w = {1'b0, x_q} - {1'b0, y_q};

    always_comb begin
        case (ctl.xsrc)
            XSRC_OPND: x_next = opa;
            XSRC_Y:    x_next = y_q;
            default:   x_next = diff_w[WIDTH-1:0];
        endcase
    end

    assign y_next = ctl.load ? opb : x_q;

    assign flags_next.lt   = diff_w[DW-1];
    assign flags_next.zero = (y_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
        end else if (ctl.x_en) begin
            x_q <= x_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
        end else if (ctl.y_en) begin
            y_q <= y_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_next;
        end
    end

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  gcd_flags_t flags,
    output gcd_ctl_t   ctl,
    output gcd_state_e state_q,
    output logic       done
);
    gcd_state_e state_n;
    logic       fresh_q;
    logic       fresh_n;

    always_comb begin
        ctl     = ctl_make(1'b0, 1'b0, 1'b0, XSRC_OPND);
        state_n = state_q;
        fresh_n = fresh_q;
        case (state_q)
            ST_RUN: begin
                if (!fresh_q) begin
                    fresh_n = 1'b1;
                end else if (flags.lt) begin
                    ctl     = ctl_make(1'b0, 1'b1, 1'b1, XSRC_Y);
                    fresh_n = 1'b0;
                end else if (!flags.zero) begin
                    ctl     = ctl_make(1'b0, 1'b1, 1'b0, XSRC_DIFF);
                    fresh_n = 1'b0;
                end else begin
                    state_n = ST_DONE;
                end
            end
            default: begin
                if (start) begin
                    ctl     = ctl_make(1'b1, 1'b1, 1'b1, XSRC_OPND);
                    state_n = ST_RUN;
                    fresh_n = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fresh_q <= 1'b0;
        end else begin
            state_q <= state_n;
            fresh_q <= fresh_n;
        end
    end

    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/gcd_sub_swap.sv
module gcd_sub_swap
    import gcd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    gcd_ctl_t         ctl_w;
    gcd_flags_t       flags_w;
    gcd_state_e       state_w;
    logic [WIDTH-1:0] x_w;
    logic [WIDTH-1:0] y_w;

    gcd_ctrl i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .flags   (flags_w),
        .ctl     (ctl_w),
        .state_q (state_w),
        .done    (done_o)
    );

    gcd_dpath #(.WIDTH(WIDTH)) i_dpath (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl_w),
        .opa     (opa_i),
        .opb     (opb_i),
        .x_q     (x_w),
        .y_q     (y_w),
        .flags_q (flags_w)
    );

    assign result_o = x_w;

endmodule

// File: rtl/gcd_sub_swap_chk.sv
module gcd_sub_swap_chk
    import gcd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             done_o,
    input logic [WIDTH-1:0] result_o,
    input gcd_ctl_t         ctl_w,
    input gcd_flags_t       flags_w,
    input gcd_state_e       state_w,
    input logic [WIDTH-1:0] x_w,
    input logic [WIDTH-1:0] y_w
);
    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_w != ST_RUN) |=> (x_w == $past(opa_i) && y_w == $past(opb_i) && !done_o));

    // R5
    swap_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_w.x_en && ctl_w.y_en && !ctl_w.load) |=> (x_w == $past(y_w) && y_w == $past(x_w)));

    // R6
    subtract_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_w.x_en && !ctl_w.y_en) |=> (x_w == $past(x_w - y_w) && y_w == $past(y_w)));

    // R4
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(flags_w.lt && flags_w.zero));

    // R7
    op_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_w.x_en && !ctl_w.load) |=> !ctl_w.x_en);

    // R8
    done_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (y_w == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(result_o)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_RUN) |-> !ctl_w.load);

endmodule

bind gcd_sub_swap gcd_sub_swap_chk #(.WIDTH(WIDTH)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .done_o   (done_o),
    .result_o (result_o),
    .ctl_w    (ctl_w),
    .flags_w  (flags_w),
    .state_w  (state_w),
    .x_w      (x_w),
    .y_w      (y_w)
);

// File: tb/test_gcd_sub_swap.sv
module test_gcd_sub_swap;
    localparam int WIDTH = 32;
    localparam int RUN_LIMIT = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [WIDTH-1:0] opa_i = '0;
    logic [WIDTH-1:0] opb_i = '0;
    logic             done_o;
    logic [WIDTH-1:0] result_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gcd_sub_swap #(.WIDTH(WIDTH)) i_gcd_sub_swap (
        .clk(clk), .rst(rst), .start_i(start_i),
        .opa_i(opa_i), .opb_i(opb_i),
        .done_o(done_o), .result_o(result_o)
    );

    function automatic logic [WIDTH-1:0] ref_gcd(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
        logic [WIDTH-1:0] t;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int ref_ops(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
        logic [WIDTH-1:0] t;
        int n = 0;
        forever begin
            if (a < b) begin
                t = a; a = b; b = t; n++;
            end else if (b != 0) begin
                a = a - b; n++;
            end else begin
                break;
            end
        end
        return n;
    endfunction

    task automatic check(bit ok, string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output int cnt);
        cnt = 0;
        while (!done_o && cnt < RUN_LIMIT) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic run_case(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, string tag);
        int cnt;
        int n;
        logic [WIDTH-1:0] exp;
        exp = ref_gcd(a, b);
        n = ref_ops(a, b);
        @(negedge clk);
        start_i = 1'b1; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0; opa_i = $urandom; opb_i = $urandom;
        // R2 / R10: loaded, done low
        check(!done_o && result_o == a, {tag, " R2 load"}, result_o, a);
        wait_done(cnt);
        // R3
        check(done_o && result_o == exp, {tag, " R3 result"}, result_o, exp);
        // R7
        check(cnt == 2 * n + 2, {tag, " R7 latency"}, cnt, 2 * n + 2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !finished) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below 150000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int cnt;
        logic [WIDTH-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: during reset
        check(!done_o && result_o == 0, "R1 in reset", result_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!done_o && result_o == 0, "R1 after reset", result_o, 0);

        run_case(32'd48, 32'd18, "basic");
        run_case(32'd7, 32'd21, "swap first R5");
        run_case(32'd100, 32'd25, "subtract R6");
        run_case(32'd0, 32'd9, "zero a");
        run_case(32'd13, 32'd0, "zero b");
        run_case(32'd0, 32'd0, "both zero");
        run_case(32'hC000_0000, 32'h4000_0000, "R4 msb diff");
        run_case(32'h7FFF_FFFF, 32'hFFFF_FFFE, "R4 full lt");
        run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, "equal max");

        // R8: hold while done
        held = result_o;
        repeat (4) @(negedge clk);
        check(done_o && result_o == held, "R8 hold", result_o, held);

        // R9: start while running is ignored
        @(negedge clk);
        start_i = 1'b1; opa_i = 32'd1000; opb_i = 32'd3;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        start_i = 1'b1; opa_i = 32'd12; opb_i = 32'd8;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(cnt);
        cnt = cnt + 5;
        check(done_o && result_o == 1, "R9 result", result_o, 1);
        check(cnt == 2 * ref_ops(32'd1000, 32'd3) + 2, "R9 latency", cnt,
              2 * ref_ops(32'd1000, 32'd3) + 2);

        // R10 and R3 under random operands
        for (int i = 0; i < 40; i++) begin
            logic [WIDTH-1:0] a;
            logic [WIDTH-1:0] b;
            a = $urandom & 32'h3FF;
            b = $urandom & 32'h3FF;
            if (i % 10 == 3) a = 0;
            if (i % 10 == 7) b = 0;
            run_case(a, b, "random R10");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule